// File: doc/BRIEF.md
# Board Interrupt Expander Controller

This block gathers up to sixteen interrupt request lines from the board and turns them into a single interrupt for the host processor. It first brings each request line into the host clock domain. Any line that is seen high is then latched as a pending event. A per-line enable mask decides which latched events may raise the host interrupt. The host interrupt is an active-high level. It stays asserted for as long as any latched line is also enabled.

The host reaches the block over a simple synchronous 16-bit register bus. The bus has a byte address, a write strobe, write data, and read data that follows the address within the same cycle. Bit i of every register belongs to line i. The host can read the latched events and the live synchronized levels. It changes the mask one bit at a time through separate set and clear addresses, and it acknowledges events with write-one-to-clear. Lines 10 and 11 usually carry two external serial ports, but the block treats them exactly like every other line.

To bring the block up, software first writes all ones to the clear address. It then writes all ones to the status address. This leaves every line disabled and every event cleared.

Top module: `irq_expander_ctrl`

## Requirements
- R1: After reset, every latched status bit and every enable bit is 0, and `host_irq` is low.
- R2: Reading offset 0x18 returns the live level of each source line after a two-flop synchronizer. A change on `irq_src` becomes visible there on the second rising clock edge after the change.
- R3: On each clock edge, a latched status bit is set when its synchronized level is high. The bit then stays set after the source falls, until it is acknowledged. A change on a source line therefore reaches the latched status on the third rising edge after the change.
- R4: A write to offset 0x16 clears every latched status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: If an acknowledge and a high synchronized level meet on the same bit in the same cycle, the status bit stays set.
- R6: A write to offset 0x1A sets every enable bit whose data bit is 1. All other enable bits are left unchanged.
- R7: A write to offset 0x1C clears every enable bit whose data bit is 1. All other enable bits are left unchanged.
- R8: A read of offset 0x16 returns the latched status. A read of either 0x1A or 0x1C returns the enable mask.
- R9: `host_irq` is high exactly when at least one line has both its status bit and its enable bit set. It stays high while that remains true.
- R10: A read of any address other than 0x16, 0x18, 0x1A or 0x1C returns 0. A write to any such address, or to 0x18, changes neither the status nor the enable mask.
- R11: All sixteen lines, including lines 10 and 11, behave identically. Line i always sits in bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_src | input | 16 | Board interrupt request levels, line i in bit i, asynchronous |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address, combinational |
| host_irq | output | 1 | Level-high summary interrupt to the host |

## Verification
The bench builds the block with its default parameters: sixteen lines, a 16-bit data word, an 8-bit address and a two-stage synchronizer. This configuration exposes the full mask, so lines 10 and 11 can be exercised alongside the edge bits 0 and 15. It also fixes the register offsets at the values the requirements name. With two synchronizer stages, the bench can predict exactly on which edge a source change appears in the live register, in the latched status and on `host_irq`. That exact timing lets it create an acknowledge that meets a still-high source on the same cycle. Random source toggles are mixed with random set, clear and acknowledge writes, including writes to the live register and to unmapped addresses.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  // Register offsets (byte addresses from block base)
  localparam int unsigned OFS_STATUS = 32'h16;
  localparam int unsigned OFS_LIVE   = 32'h18;
  localparam int unsigned OFS_EN_SET = 32'h1A;
  localparam int unsigned OFS_EN_CLR = 32'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_LIVE,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int unsigned a);
    case (a)
      OFS_STATUS: return SEL_STATUS;
      OFS_LIVE:   return SEL_LIVE;
      OFS_EN_SET: return SEL_EN_SET;
      OFS_EN_CLR: return SEL_EN_CLR;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Sticky event bit: a live level outranks an acknowledge
  function automatic logic status_bit_next(input logic cur, input logic lvl,
                                           input logic ack);
    return lvl | (cur & ~ack);
  endfunction

  // Mask bit: set and clear arrive from separate addresses
  function automatic logic enable_bit_next(input logic cur, input logic set,
                                           input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqx_line_cell.sv
module irqx_line_cell
  import irqx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic ack,
  input  logic en_set,
  input  logic en_clr,
  output logic status,
  output logic enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      enable <= 1'b0;
    end else begin
      status <= status_bit_next(status, lvl, ack);
      enable <= enable_bit_next(enable, en_set, en_clr);
    end
  end
endmodule

// File: rtl/irqx_rdmux.sv
module irqx_rdmux
  import irqx_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DATA_W = 16
) (
  input  reg_sel_e           sel,
  input  logic [LINES-1:0]   status,
  input  logic [LINES-1:0]   live,
  input  logic [LINES-1:0]   enable,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    case (sel)
      SEL_STATUS:             rdata = DATA_W'(status);
      SEL_LIVE:               rdata = DATA_W'(live);
      SEL_EN_SET, SEL_EN_CLR: rdata = DATA_W'(enable);
      default:                rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_expander_ctrl.sv
module irq_expander_ctrl
  import irqx_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_src,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 host_irq
);
  localparam int LINES = NUM_LINES;

  reg_sel_e         sel;
  logic [LINES-1:0] sync_lvl;
  logic [LINES-1:0] status_q;
  logic [LINES-1:0] enable_q;
  logic [LINES-1:0] wr_bits;
  logic [LINES-1:0] ack_vec;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] clr_vec;
  logic [LINES-1:0] pend_vec;

  assign sel     = decode_addr(32'(bus_addr));
  assign wr_bits = bus_wdata[LINES-1:0];
  assign ack_vec = (bus_we && sel == SEL_STATUS) ? wr_bits : '0;
  assign set_vec = (bus_we && sel == SEL_EN_SET) ? wr_bits : '0;
  assign clr_vec = (bus_we && sel == SEL_EN_CLR) ? wr_bits : '0;

  irqx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_src),
    .sync_out (sync_lvl)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irqx_line_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (sync_lvl[i]),
      .ack    (ack_vec[i]),
      .en_set (set_vec[i]),
      .en_clr (clr_vec[i]),
      .status (status_q[i]),
      .enable (enable_q[i])
    );
  end

  irqx_rdmux #(.LINES(LINES), .DATA_W(DATA_W)) u_rdmux (
    .sel    (sel),
    .status (status_q),
    .live   (sync_lvl),
    .enable (enable_q),
    .rdata  (bus_rdata)
  );

  assign pend_vec = status_q & enable_q;
  assign host_irq = |pend_vec;
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int LINES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_irq,
  input logic [LINES-1:0] sync_lvl,
  input logic [LINES-1:0] status_q,
  input logic [LINES-1:0] enable_q,
  input logic [LINES-1:0] ack_vec,
  input logic [LINES-1:0] set_vec,
  input logic [LINES-1:0] clr_vec
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_q == '0 && enable_q == '0 && !host_irq));

  // R3 and R5: a high synchronized level always lands in status
  assert_level_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(sync_lvl)) == $past(sync_lvl)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ack_vec & ~sync_lvl)) == '0));

  assert_en_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enable_q & $past(set_vec)) == $past(set_vec)));

  assert_en_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enable_q & $past(clr_vec)) == '0));

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(enable_q));

  assert_no_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0 || status_q == '0) |-> !host_irq);
endmodule

bind irq_expander_ctrl irqx_checker #(.LINES(NUM_LINES)) u_irqx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_irq (host_irq),
  .sync_lvl (sync_lvl),
  .status_q (status_q),
  .enable_q (enable_q),
  .ack_vec  (ack_vec),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec)
);

// File: tb/irq_expander_ctrl_bench.sv
module irq_expander_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] m_s1 = '0, m_s2 = '0, m_st = '0, m_en = '0;

  always #2 clk = ~clk;

  irq_expander_ctrl u_irq_expander_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq)
  );

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    if (a == 8'h16) return m_st;
    if (a == 8'h18) return m_s2;
    if (a == 8'h1A || a == 8'h1C) return m_en;
    return 16'h0000;
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    if (a == 8'h16) return "R8";
    if (a == 8'h18) return "R2";
    if (a == 8'h1A || a == 8'h1C) return "R8";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, update model, sample 1 ns after posedge
  task automatic cycle(input logic [15:0] src, input logic [7:0] a,
                       input logic w, input logic [15:0] d, input string tag);
    logic [15:0] st_n, en_n;
    irq_src = src; bus_addr = a; bus_we = w; bus_wdata = d;
    st_n = m_st;
    en_n = m_en;
    for (int i = 0; i < 16; i++) begin
      if (m_s2[i]) st_n[i] = 1'b1;
      else if (w && a == 8'h16 && d[i]) st_n[i] = 1'b0;
      if (w && a == 8'h1A && d[i]) en_n[i] = 1'b1;
      if (w && a == 8'h1C && d[i]) en_n[i] = 1'b0;
    end
    @(posedge clk);
    #1;
    m_s2 = m_s1; m_s1 = src; m_st = st_n; m_en = en_n;
    check((tag == "") ? tag_for(a) : tag, bus_rdata, exp_read(a));
    check("R9", {15'd0, host_irq}, {15'd0, (m_st & m_en) != 0});
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] src;
    int unsigned seed_ret;
    seed_ret = $urandom(32'h1F00BB7);
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", {15'd0, host_irq}, 16'h0);
    rst_n = 1'b1;
    cycle(16'h0, 8'h16, 1'b0, 16'h0, "R1");
    cycle(16'h0, 8'h1A, 1'b0, 16'h0, "R1");
    cycle(16'h0, 8'h18, 1'b0, 16'h0, "R1");
    // bring-up sequence: clear mask then acknowledge all (R7, R4)
    cycle(16'h0, 8'h1C, 1'b1, 16'hFFFF, "R7");
    cycle(16'h0, 8'h16, 1'b1, 16'hFFFF, "R4");
    // R11/R3: pulse line 10 for one cycle, status latches and stays
    cycle(16'h0400, 8'h18, 1'b0, 16'h0, "R2");
    cycle(16'h0000, 8'h18, 1'b0, 16'h0, "R2");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R3");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R3");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R11");
    // R6/R9: enable line 10 raises host_irq; line 11 stays off mask
    cycle(16'h0800, 8'h1A, 1'b1, 16'h0400, "R6");
    repeat (3) cycle(16'h0800, 8'h1C, 1'b0, 16'h0, "R11");
    cycle(16'h0800, 8'h16, 1'b0, 16'h0, "R11");
    // R5: acknowledge line 11 while its source is still high
    cycle(16'h0800, 8'h16, 1'b1, 16'h0800, "R5");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R5");
    // R4: acknowledge line 10 only; zero bits keep line 11
    cycle(16'h0000, 8'h16, 1'b1, 16'h0400, "R4");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R4");
    // R10: writes to live and unmapped addresses, reads of unmapped
    cycle(16'h0000, 8'h18, 1'b1, 16'hFFFF, "R10");
    cycle(16'h0000, 8'h20, 1'b1, 16'hFFFF, "R10");
    cycle(16'h0000, 8'h1A, 1'b0, 16'h0, "R10");
    cycle(16'h0000, 8'h16, 1'b0, 16'h0, "R10");
    cycle(16'h0000, 8'h17, 1'b0, 16'h0, "R10");
    // R7: clear with zero bits leaves other enables
    cycle(16'h0000, 8'h1A, 1'b1, 16'h8001, "R6");
    cycle(16'h0000, 8'h1C, 1'b1, 16'h0001, "R7");
    cycle(16'h0000, 8'h1C, 1'b0, 16'h0, "R7");
    // random mix
    src = '0;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic        w;
      logic [15:0] d;
      int unsigned pick;
      src = src ^ ($urandom & $urandom & $urandom);
      pick = $urandom % 6;
      case (pick)
        0: a = 8'h16;
        1: a = 8'h18;
        2: a = 8'h1A;
        3: a = 8'h1C;
        default: a = 8'($urandom);
      endcase
      w = ($urandom % 10) < 3;
      d = ($urandom % 2) ? (16'h1 << ($urandom % 16)) : 16'($urandom);
      cycle(src, a, w, d, "");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule